// File: doc/BRIEF.md
# Interrupt mask and acknowledge unit

This unit sits beside a processor's fetch sequencer. It takes three active-low external interrupt lines and a one-cycle timer pulse, and records each event in a pending flag. It gates the pending flags with a 4-bit mask register that software reaches over a simple data bus. It then picks the most urgent request that is allowed through and presents its vector address to the fetch logic. Software traps come in on a separate request and skip the gating.

When the sequencer starts the first-word read of a vector, the unit drives an active-low acknowledge strobe for exactly one cycle. The strobe stays one cycle long when the read is stretched by wait states. The request is then retired. Vectors sit two words apart, so hardware outside the unit can decode the source from address bits 4:1 when the strobe falls. Leaving reset, the unit requests the reset vector at address 0 and acknowledges its fetch in the same way.

Top module: `irq_mask_ack_unit`

## Requirements
- R1: The mask register answers only at bus address 0x0004. Bit 0 gates INT1, bit 1 gates INT2, bit 2 gates INT3 and bit 3 gates the timer. A read of that address returns the mask, a read of any other address returns 0, and a write to any other address leaves the mask unchanged.
- R2: Bits 15:4 of the mask address always read as 0, and data written to those bits is dropped.
- R3: Reset clears the mask to 0. After reset the unit requests vector index 0 (address 0x0000), and the first-word fetch of that vector gets one acknowledge.
- R4: A mask bit of 1 keeps its source from being requested, while its pending flag is kept. Clearing the bit later lets the request through.
- R5: While glb_en is 0, no hardware source is requested. Setting glb_en to 1 lets the pending sources through.
- R6: When several sources are eligible, INT1 is served first, then INT2, then INT3, then the timer. vec_addr is the vector index times two: 0x0002, 0x0004, 0x0006 and 0x0008. A presented vector stays stable until it is acknowledged.
- R7: ack_n is low only in the first cycle of a vector fetch (vfetch high while the previous cycle was not a wait state of the same read). It is low for exactly one cycle when wait states are present.
- R8: The acknowledge retires the claimed request and clears its pending flag in that cycle. vec_req is low in the following cycle, and each event is served once.
- R9: An INT line sets its pending flag once for each synchronized falling edge, so a line held low gives one request. A one-cycle high on tmr_pulse sets the timer flag.
- R10: A software trap (sw_trap_req with index sw_trap_idx, 5 to 15) is taken regardless of the mask and glb_en, and has precedence over hardware. It presents address index times two, gets one acknowledge, and leaves the hardware pending flags untouched. The requester holds it only while vec_req is low.
- R11: A fetch while no vector is requested produces no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Data-bus write strobe |
| bus_rd | input | 1 | Data-bus read strobe |
| bus_addr | input | 16 | Data-bus address |
| bus_wdata | input | 16 | Data-bus write data |
| bus_rdata | output | 16 | Data-bus read data (0 when not selected) |
| irq_ext_n | input | 3 | External interrupt lines, active low, asynchronous |
| tmr_pulse | input | 1 | One-cycle timer interrupt pulse |
| glb_en | input | 1 | Global enable for hardware interrupts |
| sw_trap_req | input | 1 | Software trap request |
| sw_trap_idx | input | 4 | Vector index of the trap |
| vfetch | input | 1 | Sequencer is reading the first word of the vector |
| wait_st | input | 1 | Current read cycle is extended by a wait state |
| vec_req | output | 1 | A vector is claimed and awaits fetch |
| vec_addr | output | 16 | Address of the claimed vector |
| ack_n | output | 1 | Interrupt acknowledge strobe, active low |

## Verification
A corrupted pending flag shows up as a vector presented with no event behind it, or as a lost request. Either appears on vec_req and vec_addr within two cycles of the next retire. A wrong priority or index shows as an unexpected vec_addr while the claim is held. Faulty wait-state tracking gives a second ack_n low in the same stretched read, once a follow-on claim exists. A mask or decode fault is visible on the next read of the mask address.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             valid;
    logic             hw;
    logic [IDX_W-1:0] idx;
  } claim_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_q  <= meta_q;
    end
  end
endmodule

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_n,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        s3_q <= 1'b1;
      end else begin
        s1_q <= line_n[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign fall[g] = s3_q & ~s2_q;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int                NBITS     = 4,
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NBITS-1:0]  mask
);
  logic             hit;
  logic             wr_en;
  logic [NBITS-1:0] mask_q, mask_d;

  assign hit   = (bus_addr == MASK_ADDR);
  assign wr_en = bus_wr & hit;

  always_comb begin
    mask_d = mask_q;
    if (wr_en) mask_d = bus_wdata[NBITS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= mask_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && hit) bus_rdata[NBITS-1:0] = mask_q;
  end

  assign mask = mask_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_mask_ack_unit.sv
module irq_mask_ack_unit
  import irq_pkg::*;
#(
  parameter int                NEXT      = 3,
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NEXT-1:0]   irq_ext_n,
  input  logic              tmr_pulse,
  input  logic              glb_en,
  input  logic              sw_trap_req,
  input  logic [IDX_W-1:0]  sw_trap_idx,
  input  logic              vfetch,
  input  logic              wait_st,
  output logic              vec_req,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              ack_n
);
  localparam int NSRC = NEXT + 1;
  localparam int PW   = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic            rst_q;
  logic [NEXT-1:0] ext_fall;
  logic [NSRC-1:0] req_set, mask_q, elig, clr_oh;
  logic [NSRC-1:0] pend_q, pend_d;
  logic            pick_any;
  logic [PW-1:0]   pick_idx;
  claim_t          claim_q, claim_d;
  logic            rd_cont_q, rd_cont_d;
  logic            first_cyc, ack;

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  irq_edge_sync #(.N(NEXT)) u_sync (
    .clk(clk), .rst_n(rst_q), .line_n(irq_ext_n), .fall(ext_fall)
  );

  irq_mask_reg #(
    .NBITS(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_ADDR(MASK_ADDR)
  ) u_mask (
    .clk(clk), .rst_n(rst_q), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mask(mask_q)
  );

  assign req_set = {tmr_pulse, ext_fall};
  assign elig    = pend_q & ~mask_q & {NSRC{glb_en}};

  irq_prio_pick #(.N(NSRC)) u_pick (.req(elig), .any(pick_any), .idx(pick_idx));

  // first cycle of a first-word vector read; later wait cycles are suppressed
  assign first_cyc = vfetch & ~rd_cont_q;
  assign ack       = first_cyc & claim_q.valid;
  assign rd_cont_d = vfetch & wait_st;

  always_comb begin
    clr_oh = '0;
    if (ack && claim_q.hw) clr_oh[PW'(claim_q.idx - IDX_W'(1))] = 1'b1;
    pend_d = (pend_q & ~clr_oh) | req_set;
  end

  always_comb begin
    claim_d = claim_q;
    if (ack) begin
      claim_d.valid = 1'b0;
    end else if (!claim_q.valid) begin
      if (sw_trap_req) begin
        claim_d = '{valid: 1'b1, hw: 1'b0, idx: sw_trap_idx};
      end else if (pick_any) begin
        claim_d = '{valid: 1'b1, hw: 1'b1, idx: IDX_W'(pick_idx) + IDX_W'(1)};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pend_q    <= '0;
      claim_q   <= '{valid: 1'b1, hw: 1'b0, idx: '0};
      rd_cont_q <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      claim_q   <= claim_d;
      rd_cont_q <= rd_cont_d;
    end
  end

  assign vec_req  = claim_q.valid;
  assign vec_addr = ADDR_W'({claim_q.idx, 1'b0});
  assign ack_n    = ~ack;
endmodule

// File: rtl/irq_mask_ack_chk.sv
module irq_mask_ack_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int NBITS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_n,
  input logic              vec_req,
  input logic [ADDR_W-1:0] vec_addr,
  input logic [DATA_W-1:0] bus_rdata
);
  // R7
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |=> ack_n);

  // R11
  ack_needs_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> vec_req);

  // R8
  claim_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |=> !vec_req);

  // R6
  claim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && ack_n) |=> (vec_req && $stable(vec_addr)));

  // R6
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (vec_addr[0] == 1'b0 && vec_addr[ADDR_W-1:5] == '0));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NBITS] == '0);
endmodule

bind irq_mask_ack_unit irq_mask_ack_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBITS(NEXT + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .vec_req(vec_req),
  .vec_addr(vec_addr), .bus_rdata(bus_rdata)
);

// File: tb/tb_irq_mask_ack_unit.sv
`timescale 1ns/1ps
module tb_irq_mask_ack_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic [2:0]  irq_ext_n;
  logic        tmr_pulse, glb_en, sw_trap_req;
  logic [3:0]  sw_trap_idx;
  logic        vfetch, wait_st;
  logic        vec_req, ack_n;
  logic [15:0] vec_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_mask_ack_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ext_n(irq_ext_n), .tmr_pulse(tmr_pulse), .glb_en(glb_en),
    .sw_trap_req(sw_trap_req), .sw_trap_idx(sw_trap_idx),
    .vfetch(vfetch), .wait_st(wait_st),
    .vec_req(vec_req), .vec_addr(vec_addr), .ack_n(ack_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (7) @(negedge clk);
    #1;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic pulse_ext(input int i);
    @(negedge clk);
    irq_ext_n[i] = 1'b0;
    repeat (3) @(negedge clk);
    irq_ext_n[i] = 1'b1;
  endtask

  task automatic pulse_tmr();
    @(negedge clk);
    tmr_pulse = 1'b1;
    @(negedge clk);
    tmr_pulse = 1'b0;
  endtask

  task automatic do_fetch(input int nw, output int lows);
    lows = 0;
    for (int c = 0; c <= nw; c++) begin
      @(negedge clk);
      vfetch = 1'b1; wait_st = (c < nw);
      #1 if (!ack_n) lows++;
    end
    @(negedge clk);
    vfetch = 1'b0; wait_st = 1'b0;
  endtask

  task automatic expect_vec(input string req, input logic [15:0] a);
    chk(vec_req === 1'b1, req, "vec_req", int'(vec_req), 1);
    chk(vec_addr === a, req, "vec_addr", int'(vec_addr), int'(a));
  endtask

  task automatic t_reset();
    logic [15:0] d;
    int lows;
    #1;
    chk(ack_n === 1'b1, "R3", "ack_n in reset", int'(ack_n), 1);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 expect_vec("R3", 16'h0000);
    bus_read(16'h0004, d);
    chk(d === 16'h0000, "R3", "mask after reset", int'(d), 0);
    do_fetch(0, lows);
    chk(lows == 1, "R3", "reset vector acks", lows, 1);
    settle();
    chk(vec_req === 1'b0, "R8", "vec_req after reset ack", int'(vec_req), 0);
  endtask

  task automatic t_mask_rw();
    logic [15:0] d;
    bus_write(16'h0004, 16'h000A);
    bus_read(16'h0004, d);
    chk(d === 16'h000A, "R1", "mask readback", int'(d), 'hA);
    bus_write(16'h0004, 16'hFFF5);
    bus_read(16'h0004, d);
    chk(d === 16'h0005, "R2", "reserved bits dropped", int'(d), 5);
    bus_read(16'h0006, d);
    chk(d === 16'h0000, "R1", "other address reads 0", int'(d), 0);
    bus_write(16'h0006, 16'h000F);
    bus_read(16'h0004, d);
    chk(d === 16'h0005, "R1", "other address write ignored", int'(d), 5);
  endtask

  task automatic t_mask_block();
    int lows;
    glb_en = 1'b1;
    bus_write(16'h0004, 16'h000F);
    pulse_ext(1);
    settle();
    chk(vec_req === 1'b0, "R4", "masked INT2 blocked", int'(vec_req), 0);
    bus_write(16'h0004, 16'h000D);
    settle();
    expect_vec("R4", 16'h0004);
    do_fetch(0, lows);
    chk(lows == 1, "R7", "INT2 ack count", lows, 1);
    settle();
    chk(vec_req === 1'b0, "R8", "INT2 served once", int'(vec_req), 0);
  endtask

  task automatic t_gen_block();
    int lows;
    bus_write(16'h0004, 16'h0000);
    glb_en = 1'b0;
    pulse_ext(2);
    settle();
    chk(vec_req === 1'b0, "R5", "glb_en low blocks", int'(vec_req), 0);
    glb_en = 1'b1;
    settle();
    expect_vec("R5", 16'h0006);
    do_fetch(0, lows);
    settle();
  endtask

  task automatic t_priority();
    int lows;
    bus_write(16'h0004, 16'h000F);
    pulse_tmr();
    pulse_ext(2);
    pulse_ext(1);
    pulse_ext(0);
    settle();
    chk(vec_req === 1'b0, "R4", "all masked", int'(vec_req), 0);
    bus_write(16'h0004, 16'h0000);
    settle();
    expect_vec("R6", 16'h0002);
    do_fetch(0, lows);
    settle();
    expect_vec("R6", 16'h0004);
    do_fetch(0, lows);
    settle();
    expect_vec("R6", 16'h0006);
    do_fetch(0, lows);
    settle();
    expect_vec("R9", 16'h0008);
    do_fetch(0, lows);
    chk(lows == 1, "R7", "timer ack count", lows, 1);
    settle();
    chk(vec_req === 1'b0, "R8", "all served", int'(vec_req), 0);
  endtask

  task automatic t_wait_ack();
    int lows;
    pulse_ext(0);
    pulse_ext(1);
    settle();
    expect_vec("R6", 16'h0002);
    do_fetch(3, lows);
    chk(lows == 1, "R7", "ack lows with 3 wait states", lows, 1);
    settle();
    expect_vec("R8", 16'h0004);
    do_fetch(2, lows);
    chk(lows == 1, "R7", "ack lows with 2 wait states", lows, 1);
    settle();
    chk(vec_req === 1'b0, "R8", "after waited fetches", int'(vec_req), 0);
  endtask

  task automatic t_trap();
    int lows;
    bus_write(16'h0004, 16'h000F);
    glb_en = 1'b0;
    pulse_ext(0);
    settle();
    chk(vec_req === 1'b0, "R10", "INT1 blocked before trap", int'(vec_req), 0);
    @(negedge clk);
    sw_trap_req = 1'b1; sw_trap_idx = 4'd6;
    @(negedge clk);
    sw_trap_req = 1'b0;
    #1 expect_vec("R10", 16'h000C);
    do_fetch(0, lows);
    chk(lows == 1, "R10", "trap ack count", lows, 1);
    settle();
    chk(vec_req === 1'b0, "R10", "trap leaves INT1 blocked", int'(vec_req), 0);
    bus_write(16'h0004, 16'h0000);
    glb_en = 1'b1;
    settle();
    expect_vec("R10", 16'h0002);
    do_fetch(0, lows);
    settle();
  endtask

  task automatic t_held_low();
    int lows;
    @(negedge clk) irq_ext_n[2] = 1'b0;
    settle();
    expect_vec("R9", 16'h0006);
    do_fetch(0, lows);
    repeat (12) @(negedge clk);
    #1 chk(vec_req === 1'b0, "R9", "held-low line single request", int'(vec_req), 0);
    irq_ext_n[2] = 1'b1;
    settle();
    chk(vec_req === 1'b0, "R9", "rising edge no request", int'(vec_req), 0);
  endtask

  task automatic t_noclaim();
    int lows;
    do_fetch(0, lows);
    chk(lows == 0, "R11", "fetch without claim", lows, 0);
    do_fetch(2, lows);
    chk(lows == 0, "R11", "waited fetch without claim", lows, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    irq_ext_n = '1; tmr_pulse = 1'b0; glb_en = 1'b0;
    sw_trap_req = 1'b0; sw_trap_idx = '0; vfetch = 1'b0; wait_st = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_mask_rw();
    t_mask_block();
    t_gen_block();
    t_priority();
    t_wait_ack();
    t_trap();
    t_held_low();
    t_noclaim();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule